// File: doc/BRIEF.md
# Event Context Save/Restore Sequencer

This block moves processor context between the core and a downward-growing system stack in memory. When the core accepts an event, the block takes a snapshot of the status register, the return address and, for the four interrupt levels only, the five scratch registers R8 to R12 and the link register. It then writes the snapshot out one word per transfer through a valid/ready memory port. When the core executes a return-from-event, the block reads the frame back in the reverse order. For each word it pulses a restore strobe so the core can reload the status register, the program counter or a register.

System calls and debug requests need no automatic save, so the block ignores them. Before it writes anything, the block checks that the whole frame fits above a programmable stack limit. If the frame does not fit, the block raises an overflow pulse and issues no memory transfers. At the end of a sequence the block pulses done together with the updated stack pointer. Handler address computation and event priority are handled elsewhere.

Top module: `ctx_stack_seq`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `busy_o`, `mem_valid_o`, `done_o`, `overflow_o`, `sp_load_o` and every restore strobe are low.
- R2: An accepted event whose type code is 0 to 3 (interrupt levels 0 to 3) writes eight words. The first word is R8 at sp-4, then R9, R10, R11, R12 and the link register, then the return address and finally the status register at sp-32, each at the next lower word address.
- R3: An accepted event whose type code is 4 or 7 (exceptions and other non-interrupt events) writes the return address at sp-4 and then the status register at sp-8.
- R4: An accept with type code 5 (system call) or 6 (debug request) causes no memory transfer, no done and no overflow.
- R5: If the frame of N words would place its lowest word below `sp_limit_i`, or if sp is below 4·N so the address would wrap, `overflow_o` pulses for one cycle in the cycle after the accept. No memory request and no done follow.
- R6: A return pops from the current sp upward in the exact reverse of the push order. The status register comes from sp, the return address from sp+4, and for type codes 0 to 3 the link register and then R12 down to R8 follow from sp+8 to sp+28. Each word produces one restore strobe in the cycle after its transfer.
- R7: While `mem_valid_o` is high and `mem_ready_i` is low, the block holds the request. Valid, write enable, address and write data stay unchanged, and the block waits without losing a transfer.
- R8: `done_o` is a single-cycle pulse in the cycle after the last transfer. It comes together with `sp_load_o`, and `sp_val_o` carries sp-4·N after a save or sp+4·N after a restore.
- R9: An accept or a return that arrives while `busy_o` is high is ignored and does not change the sequence in progress.
- R10: `gpr_idx_o` encodes the reloaded register as 0..4 for R8..R12 and 5 for the link register. At most one of `sr_load_o`, `pc_load_o` and `gpr_load_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| accept_i | input | 1 | Event accepted this cycle |
| ret_i | input | 1 | Return-from-event this cycle (accept wins if both are high) |
| evt_type_i | input | 3 | Event class code, see R2 to R4 |
| sr_i | input | DATA_W | Current status register |
| pc_i | input | DATA_W | Return address to save |
| lr_i | input | DATA_W | Current link register |
| regs_i | input | NUM_GPR·DATA_W | R8..R12 packed, R8 in the lowest slice |
| sp_i | input | ADDR_W | Current system stack pointer |
| sp_limit_i | input | ADDR_W | Lowest legal stack address |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address of the word |
| mem_wdata_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | DATA_W | Read data, valid in the handshake cycle |
| busy_o | output | 1 | Sequence in progress |
| sr_load_o | output | 1 | Reload the status register from `restore_val_o` |
| pc_load_o | output | 1 | Reload the program counter from `restore_val_o` |
| gpr_load_o | output | 1 | Reload the register selected by `gpr_idx_o` |
| gpr_idx_o | output | 3 | Register select, see R10 |
| restore_val_o | output | DATA_W | Value for the active restore strobe |
| sp_load_o | output | 1 | Stack pointer update strobe |
| sp_val_o | output | ADDR_W | New stack pointer |
| done_o | output | 1 | Sequence complete |
| overflow_o | output | 1 | Frame does not fit above the limit |

## Verification
The bench aims at the limit boundary from both sides. Frames that end exactly on `sp_limit_i` must be written, and frames one word short of fitting must raise overflow, so a design with an off-by-one compare either rejects a legal frame or writes below the limit. A stack pointer near zero tests wrap-around: a design that ignores the borrow would write to the top of memory. Randomly stalled ready tests that a design advancing its counter without a handshake would skip or duplicate words. Each save is paired with a return of the same class, so a design that pops in the wrong order or with the wrong frame length would reload the wrong registers. Accepts of the bypassed classes and accepts during a busy sequence must leave memory, done and overflow untouched.

// File: rtl/ctx_seq_pkg.sv
// Shared types and event class decoding for the context sequencer.
// Assumes a 3-bit event class code: 0..3 interrupt levels, 4 and 7 other
// events with a short frame, 5 system call, 6 debug request.
package ctx_seq_pkg;

    localparam int EVT_W = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SAVE,
        SEQ_LOAD,
        SEQ_FIN
    } seq_state_e;

    // True for the four interrupt levels, which use the extended frame
    function automatic logic is_irq_level(input logic [EVT_W-1:0] code);
        return (code[EVT_W-1] == 1'b0);
    endfunction

    // True for classes that skip the automatic context save
    function automatic logic skips_save(input logic [EVT_W-1:0] code);
        return (code == 3'd5) || (code == 3'd6);
    endfunction

endpackage

// File: rtl/ctx_frame_check.sv
// Frame fit check: computes the frame size in bytes, the stack pointer after
// the whole frame, and whether a downward frame stays at or above the limit
// without wrapping below address zero. Purely combinational.
module ctx_frame_check #(
    parameter int ADDR_W      = 32,
    parameter int EXT_WORDS   = 8,
    parameter int SHORT_WORDS = 2,
    parameter int BPW         = 4
) (
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ADDR_W-1:0] limit_i,
    input  logic              extended_i,
    input  logic              grow_down_i,
    output logic [ADDR_W-1:0] sp_after_o,
    output logic              fits_o
);

    localparam logic [ADDR_W-1:0] EXT_BYTES   = ADDR_W'(EXT_WORDS * BPW);
    localparam logic [ADDR_W-1:0] SHORT_BYTES = ADDR_W'(SHORT_WORDS * BPW);

    logic [ADDR_W-1:0] nbytes;
    logic [ADDR_W-1:0] lowest;

    // Frame size selection and resulting pointers
    always_comb begin
        nbytes     = extended_i ? EXT_BYTES : SHORT_BYTES;
        lowest     = sp_i - nbytes;
        sp_after_o = grow_down_i ? lowest : (sp_i + nbytes);
        fits_o     = (sp_i >= nbytes) && (lowest >= limit_i);
    end

endmodule

// File: rtl/ctx_addr_gen.sv
// Word address generator. A save pre-decrements: transfer k goes to
// base - (k+1)*BPW. A restore post-increments: transfer k comes from
// base + k*BPW. Assumes the fit check has already excluded wrap-around.
module ctx_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 4,
    parameter int BPW    = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              grow_down_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] steps;
    logic [ADDR_W-1:0] offset;

    // Offset from the captured base for the current transfer
    always_comb begin
        steps  = ADDR_W'(cnt_i) + ADDR_W'(grow_down_i);
        offset = steps * ADDR_W'(BPW);
        addr_o = grow_down_i ? (base_i - offset) : (base_i + offset);
    end

endmodule

// File: rtl/ctx_stack_seq.sv
// Event context save/restore sequencer.
// On an accepted event it snapshots the context and writes it to a
// downward-growing stack, one word per valid/ready transfer. On a return it
// reads the frame back in reverse order and pulses restore strobes.
// Assumes: accept_i and ret_i are single-cycle pulses, are ignored while
// busy, and memory read data is valid in the handshake cycle.
module ctx_stack_seq
    import ctx_seq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int NUM_GPR = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        accept_i,
    input  logic                        ret_i,
    input  logic [2:0]                  evt_type_i,
    input  logic [DATA_W-1:0]           sr_i,
    input  logic [DATA_W-1:0]           pc_i,
    input  logic [DATA_W-1:0]           lr_i,
    input  logic [NUM_GPR*DATA_W-1:0]   regs_i,
    input  logic [ADDR_W-1:0]           sp_i,
    input  logic [ADDR_W-1:0]           sp_limit_i,
    output logic                        mem_valid_o,
    output logic                        mem_we_o,
    output logic [ADDR_W-1:0]           mem_addr_o,
    output logic [DATA_W-1:0]           mem_wdata_o,
    input  logic                        mem_ready_i,
    input  logic [DATA_W-1:0]           mem_rdata_i,
    output logic                        busy_o,
    output logic                        sr_load_o,
    output logic                        pc_load_o,
    output logic                        gpr_load_o,
    output logic [$clog2(NUM_GPR+3)-1:0] gpr_idx_o,
    output logic [DATA_W-1:0]           restore_val_o,
    output logic                        sp_load_o,
    output logic [ADDR_W-1:0]           sp_val_o,
    output logic                        done_o,
    output logic                        overflow_o
);

    // Frame layout: slots 0..NUM_GPR-1 scratch registers, then LR, RA, SR
    localparam int FRAME_EXT   = NUM_GPR + 3;
    localparam int FRAME_SHORT = 2;
    localparam int BPW         = DATA_W / 8;
    localparam int IDX_W       = $clog2(FRAME_EXT);
    localparam int CNT_W       = $clog2(FRAME_EXT + 1);
    localparam int LR_IDX      = NUM_GPR;
    localparam int PC_IDX      = NUM_GPR + 1;
    localparam int SR_IDX      = NUM_GPR + 2;

    seq_state_e          state_q;
    logic                grow_down_q;
    logic                ext_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    last_cnt;
    logic [ADDR_W-1:0]   base_q;
    logic [ADDR_W-1:0]   sp_after_q;
    logic                ovf_q;
    logic [DATA_W-1:0]   snap    [FRAME_EXT];
    logic [DATA_W-1:0]   frame_q [FRAME_EXT];
    logic [IDX_W-1:0]    first_idx;
    logic [IDX_W-1:0]    slot;
    logic                hs;
    logic                req_ext;
    logic                fc_fits;
    logic [ADDR_W-1:0]   fc_sp_after;
    logic                start_save;
    logic                start_load;
    logic                idle;

    // Snapshot wiring: scratch registers from the packed bus
    for (genvar g = 0; g < NUM_GPR; g++) begin : g_snap
        assign snap[g] = regs_i[g*DATA_W +: DATA_W];
    end
    assign snap[LR_IDX] = lr_i;
    assign snap[PC_IDX] = pc_i;
    assign snap[SR_IDX] = sr_i;

    // Start decoding for a new sequence
    always_comb begin
        idle       = (state_q == SEQ_IDLE);
        req_ext    = is_irq_level(evt_type_i);
        start_save = idle && accept_i && !skips_save(evt_type_i);
        start_load = idle && !accept_i && ret_i;
    end

    ctx_frame_check #(
        .ADDR_W      (ADDR_W),
        .EXT_WORDS   (FRAME_EXT),
        .SHORT_WORDS (FRAME_SHORT),
        .BPW         (BPW)
    ) u_fit (
        .sp_i        (sp_i),
        .limit_i     (sp_limit_i),
        .extended_i  (req_ext),
        .grow_down_i (accept_i),
        .sp_after_o  (fc_sp_after),
        .fits_o      (fc_fits)
    );

    // Slot selection for the current transfer
    always_comb begin
        last_cnt  = ext_q ? CNT_W'(FRAME_EXT - 1) : CNT_W'(FRAME_SHORT - 1);
        first_idx = ext_q ? '0 : IDX_W'(PC_IDX);
        slot      = grow_down_q ? (first_idx + IDX_W'(cnt_q))
                                : (IDX_W'(SR_IDX) - IDX_W'(cnt_q));
    end

    ctx_addr_gen #(
        .ADDR_W      (ADDR_W),
        .CNT_W       (CNT_W),
        .BPW         (BPW)
    ) u_addr (
        .base_i      (base_q),
        .cnt_i       (cnt_q),
        .grow_down_i (grow_down_q),
        .addr_o      (mem_addr_o)
    );

    // Memory port drive
    always_comb begin
        mem_valid_o = (state_q == SEQ_SAVE) || (state_q == SEQ_LOAD);
        mem_we_o    = (state_q == SEQ_SAVE);
        mem_wdata_o = frame_q[slot];
        hs          = mem_valid_o && mem_ready_i;
    end

    // Sequencer state, transfer counter and overflow pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SEQ_IDLE;
            grow_down_q <= 1'b0;
            ext_q       <= 1'b0;
            cnt_q       <= '0;
            base_q      <= '0;
            sp_after_q  <= '0;
            ovf_q       <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    cnt_q <= '0;
                    if (start_save) begin
                        if (fc_fits) begin
                            state_q     <= SEQ_SAVE;
                            grow_down_q <= 1'b1;
                            ext_q       <= req_ext;
                            base_q      <= sp_i;
                            sp_after_q  <= fc_sp_after;
                        end else begin
                            ovf_q <= 1'b1;
                        end
                    end else if (start_load) begin
                        state_q     <= SEQ_LOAD;
                        grow_down_q <= 1'b0;
                        ext_q       <= req_ext;
                        base_q      <= sp_i;
                        sp_after_q  <= fc_sp_after;
                    end
                end
                SEQ_SAVE, SEQ_LOAD: begin
                    if (hs) begin
                        if (cnt_q == last_cnt) begin
                            state_q <= SEQ_FIN;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end

    // Context snapshot taken when a save starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < FRAME_EXT; k++) begin
                frame_q[k] <= '0;
            end
        end else if (start_save) begin
            frame_q <= snap;
        end
    end

    // Restore strobes, registered one cycle after each read handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_load_o     <= 1'b0;
            pc_load_o     <= 1'b0;
            gpr_load_o    <= 1'b0;
            gpr_idx_o     <= '0;
            restore_val_o <= '0;
        end else begin
            sr_load_o  <= 1'b0;
            pc_load_o  <= 1'b0;
            gpr_load_o <= 1'b0;
            if ((state_q == SEQ_LOAD) && hs) begin
                restore_val_o <= mem_rdata_i;
                if (slot == IDX_W'(SR_IDX)) begin
                    sr_load_o <= 1'b1;
                end else if (slot == IDX_W'(PC_IDX)) begin
                    pc_load_o <= 1'b1;
                end else begin
                    gpr_load_o <= 1'b1;
                    gpr_idx_o  <= slot;
                end
            end
        end
    end

    // Completion and status outputs
    always_comb begin
        busy_o     = !idle;
        done_o     = (state_q == SEQ_FIN);
        sp_load_o  = (state_q == SEQ_FIN);
        sp_val_o   = sp_after_q;
        overflow_o = ovf_q;
    end

endmodule

// File: rtl/ctx_seq_checker.sv
// Protocol checker for the context sequencer, bound to every instance.
// Assumes the checker sees the top-level ports only.
module ctx_seq_checker #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32,
    parameter int MAX_IDX = 5,
    parameter int IDX_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept_i,
    input logic [2:0]        evt_type_i,
    input logic              busy_o,
    input logic              mem_valid_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_ready_i,
    input logic              sr_load_o,
    input logic              pc_load_o,
    input logic              gpr_load_o,
    input logic [IDX_W-1:0]  gpr_idx_o,
    input logic              sp_load_o,
    input logic              done_o,
    input logic              overflow_o
);

    // R7: a stalled request is held unchanged
    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)
            && $stable(mem_wdata_o) && $stable(mem_we_o)));

    // R8: done lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done comes with the stack pointer update
    assert_done_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> sp_load_o);

    // R5: overflow comes with no request and no completion
    assert_ovf_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (!mem_valid_o && !done_o && !busy_o));

    // R4: bypassed classes start nothing
    assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && accept_i && (evt_type_i == 3'd5 || evt_type_i == 3'd6))
            |=> (!mem_valid_o && !overflow_o));

    // R10: one restore strobe at a time
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sr_load_o, pc_load_o, gpr_load_o}));

    // R10: register index stays within R8..R12 and LR
    assert_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_load_o |-> (32'(gpr_idx_o) <= MAX_IDX));

endmodule

bind ctx_stack_seq ctx_seq_checker #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .MAX_IDX (NUM_GPR),
    .IDX_W   ($clog2(NUM_GPR+3))
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept_i),
    .evt_type_i  (evt_type_i),
    .busy_o      (busy_o),
    .mem_valid_o (mem_valid_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .sr_load_o   (sr_load_o),
    .pc_load_o   (pc_load_o),
    .gpr_load_o  (gpr_load_o),
    .gpr_idx_o   (gpr_idx_o),
    .sp_load_o   (sp_load_o),
    .done_o      (done_o),
    .overflow_o  (overflow_o)
);

// File: tb/ctx_stack_seq_test.sv
`timescale 1ns/1ps
module ctx_stack_seq_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         accept_i = 1'b0;
    logic         ret_i = 1'b0;
    logic [2:0]   evt_type_i = '0;
    logic [31:0]  sr_i = '0, pc_i = '0, lr_i = '0;
    logic [159:0] regs_i = '0;
    logic [31:0]  sp_i = '0, sp_limit_i = '0;
    logic         mem_valid_o, mem_we_o, mem_ready_i;
    logic [31:0]  mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic         busy_o, sr_load_o, pc_load_o, gpr_load_o;
    logic [2:0]   gpr_idx_o;
    logic [31:0]  restore_val_o, sp_val_o;
    logic         sp_load_o, done_o, overflow_o;

    always #4 clk = ~clk;

    ctx_stack_seq uut (
        .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .ret_i(ret_i),
        .evt_type_i(evt_type_i), .sr_i(sr_i), .pc_i(pc_i), .lr_i(lr_i),
        .regs_i(regs_i), .sp_i(sp_i), .sp_limit_i(sp_limit_i),
        .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .sr_load_o(sr_load_o), .pc_load_o(pc_load_o),
        .gpr_load_o(gpr_load_o), .gpr_idx_o(gpr_idx_o), .restore_val_o(restore_val_o),
        .sp_load_o(sp_load_o), .sp_val_o(sp_val_o), .done_o(done_o), .overflow_o(overflow_o)
    );

    // Stimulus table: [39:37] class, [36] stall, [35:20] sp, [19:4] limit,
    // [3:0] expected words (0 = bypassed, F = overflow)
    localparam int NV = 10;
    localparam logic [39:0] VEC [NV] = '{
        {3'd0, 1'b0, 16'h1100, 16'h1000, 4'h8},
        {3'd3, 1'b1, 16'h1080, 16'h1060, 4'h8},
        {3'd1, 1'b1, 16'h10C0, 16'h1000, 4'h8},
        {3'd4, 1'b0, 16'h1040, 16'h1000, 4'h2},
        {3'd7, 1'b1, 16'h1010, 16'h1008, 4'h2},
        {3'd2, 1'b0, 16'h1078, 16'h1060, 4'hF},
        {3'd4, 1'b0, 16'h1004, 16'h1000, 4'hF},
        {3'd0, 1'b0, 16'h0004, 16'h0000, 4'hF},
        {3'd5, 1'b0, 16'h1040, 16'h1000, 4'h0},
        {3'd6, 1'b1, 16'h1040, 16'h1000, 4'h0}
    };

    int nchk = 0, nfail = 0;
    logic stall = 1'b0;
    int tick = 0;
    logic [31:0] mem [64];
    logic [31:0] wa [256], wd [256], ra [256], sv [256];
    int sc [256];
    int wn = 0, rn = 0, sn = 0, dn = 0, on = 0;
    logic [31:0] dsp = '0;

    assign mem_rdata_i = mem[mem_addr_o[7:2]];

    function automatic logic [31:0] fw(input int v, input int k);
        return 32'h5A00_0000 + 32'(v * 256) + 32'(k * 17) + 32'd1;
    endfunction

    // Ready generation and observation of every handshake and strobe
    always @(negedge clk) begin
        tick = tick + 1;
        mem_ready_i = stall ? ((tick % 3) == 2) : 1'b1;
        if (rst_n) begin
            if (mem_valid_o && mem_ready_i) begin
                if (mem_we_o) begin
                    wa[wn[7:0]] = mem_addr_o; wd[wn[7:0]] = mem_wdata_o; wn = wn + 1;
                end else begin
                    ra[rn[7:0]] = mem_addr_o; rn = rn + 1;
                end
            end
            if (sr_load_o) begin sc[sn[7:0]] = 7; sv[sn[7:0]] = restore_val_o; sn = sn + 1; end
            if (pc_load_o) begin sc[sn[7:0]] = 6; sv[sn[7:0]] = restore_val_o; sn = sn + 1; end
            if (gpr_load_o) begin sc[sn[7:0]] = int'(gpr_idx_o); sv[sn[7:0]] = restore_val_o; sn = sn + 1; end
            if (done_o) begin dn = dn + 1; dsp = sp_val_o; end
            if (overflow_o) on = on + 1;
        end
    end

    // Memory model
    always @(posedge clk) begin
        if (mem_valid_o && mem_ready_i && mem_we_o && mem_addr_o[31:8] == 24'h10)
            mem[mem_addr_o[7:2]] <= mem_wdata_o;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic fire(input logic acc, input logic ret, input logic [2:0] t,
                        input logic [31:0] sp, input logic [31:0] lim, input int v);
        @(negedge clk);
        accept_i = acc; ret_i = ret; evt_type_i = t; sp_i = sp; sp_limit_i = lim;
        sr_i = fw(v, 7); pc_i = fw(v, 6); lr_i = fw(v, 5);
        for (int g = 0; g < 5; g++) regs_i[g*32 +: 32] = fw(v, g);
        @(negedge clk);
        accept_i = 1'b0; ret_i = 1'b0;
    endtask

    task automatic wait_end(input int d0, input int o0);
        for (int i = 0; i < 200; i++) begin
            if (dn != d0 || on != o0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        nfail = nfail + 1;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int w0, r0, s0, d0, o0, n, first, code;
        logic [31:0] sp, lim;
        logic [2:0] t;
        string rq;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: idle state during reset
        chk(!busy_o && !mem_valid_o && !done_o && !overflow_o && !sp_load_o,
            "R1", "reset idle", {27'd0, busy_o, mem_valid_o, done_o, overflow_o, sp_load_o}, 32'd0);
        chk(!sr_load_o && !pc_load_o && !gpr_load_o, "R1", "reset strobes",
            {29'd0, sr_load_o, pc_load_o, gpr_load_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table-driven save/restore pairs
        for (int v = 0; v < NV; v++) begin
            t = VEC[v][39:37]; stall = VEC[v][36];
            sp = {16'h0, VEC[v][35:20]}; lim = {16'h0, VEC[v][19:4]};
            n = int'(VEC[v][3:0]);
            w0 = wn; r0 = rn; s0 = sn; d0 = dn; o0 = on;
            fire(1'b1, 1'b0, t, sp, lim, v);
            if (n == 0) begin
                repeat (20) @(negedge clk);
                // R4: bypassed class leaves everything quiet
                chk(wn == w0 && dn == d0 && on == o0, "R4", "bypass activity",
                    32'(wn - w0 + dn - d0 + on - o0), 32'd0);
                continue;
            end
            wait_end(d0, o0);
            if (n == 15) begin
                // R5: overflow pulse, no writes, no done
                chk(on - o0 == 1, "R5", "overflow pulses", 32'(on - o0), 32'd1);
                chk(wn == w0 && dn == d0, "R5", "writes+done on overflow",
                    32'(wn - w0 + dn - d0), 32'd0);
                continue;
            end
            rq = stall ? "R7" : ((n == 8) ? "R2" : "R3");
            first = (n == 8) ? 0 : 6;
            chk(wn - w0 == n, rq, "write count", 32'(wn - w0), 32'(n));
            for (int i = 0; i < n && i < wn - w0; i++) begin
                chk(wa[8'(w0 + i)] == sp - 32'(4 * (i + 1)), rq, "write addr",
                    wa[8'(w0 + i)], sp - 32'(4 * (i + 1)));
                chk(wd[8'(w0 + i)] == fw(v, first + i), rq, "write data",
                    wd[8'(w0 + i)], fw(v, first + i));
            end
            chk(dn - d0 == 1 && dsp == sp - 32'(4 * n), "R8", "save done/sp", dsp, sp - 32'(4 * n));

            // Return of the same class restores the saved frame
            d0 = dn;
            fire(1'b0, 1'b1, t, sp - 32'(4 * n), 32'h0, 99);
            wait_end(d0, on);
            rq = stall ? "R7" : "R6";
            chk(rn - r0 == n, rq, "read count", 32'(rn - r0), 32'(n));
            for (int i = 0; i < n && i < rn - r0; i++)
                chk(ra[8'(r0 + i)] == sp - 32'(4 * n) + 32'(4 * i), rq, "read addr",
                    ra[8'(r0 + i)], sp - 32'(4 * n) + 32'(4 * i));
            chk(sn - s0 == n, "R6", "restore strobes", 32'(sn - s0), 32'(n));
            for (int i = 0; i < n && i < sn - s0; i++) begin
                code = 7 - i;
                chk(sc[8'(s0 + i)] == code, "R10", "restore target",
                    32'(sc[8'(s0 + i)]), 32'(code));
                chk(sv[8'(s0 + i)] == fw(v, code), "R6", "restore value",
                    sv[8'(s0 + i)], fw(v, code));
            end
            chk(dn - d0 == 1 && dsp == sp, "R8", "restore done/sp", dsp, sp);
        end

        // R9: accept and return during a busy save are ignored
        stall = 1'b1;
        w0 = wn; r0 = rn; d0 = dn; o0 = on;
        fire(1'b1, 1'b0, 3'd0, 32'h1100, 32'h1000, 20);
        repeat (2) @(negedge clk);
        fire(1'b1, 1'b1, 3'd4, 32'h1040, 32'h1000, 21);
        wait_end(d0, o0);
        repeat (10) @(negedge clk);
        chk(wn - w0 == 8 && rn == r0, "R9", "transfers with busy accept", 32'(wn - w0), 32'd8);
        chk(dn - d0 == 1 && dsp == 32'h10E0, "R9", "single done/sp", dsp, 32'h10E0);
        chk(wd[8'(w0 + 7)] == fw(20, 7), "R9", "frame kept", wd[8'(w0 + 7)], fw(20, 7));

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule